// File: doc/BRIEF.md
# Shutdown Pin Mode Sequencer

This block watches an active-low shutdown pin and powers the surrounding amplifier down in one of three ways. A 2-bit mode field picks the behaviour. The first choice is an orderly power-down that ends in a full hardware shutdown, with register defaults restored and the control bus disabled. The second is an immediate hardware shutdown. The third is an orderly power-down into a software shutdown, where register contents are kept and the control bus stays usable.

The orderly power-down has three steps: a volume ramp-down request (only when ramping is enabled), a stop of the switching stage, and the analog and digital power-down enables. Each step ends when the controlled block answers with a done pulse, or when a programmable cycle timeout expires, whichever comes first. When the pin is released, the block latches the two address-strap inputs and settles in software shutdown. A release that arrives during the power-down is recorded as an abort and is honoured only after the power-down has finished.

Top module: `shutdown_seq_top`

## Requirements
- R1: After reset, `bus_en` is 1. `ramp_req`, `switch_stop`, `ana_pd`, `dig_pd`, `reg_reset`, `hw_off`, `sw_off` and `seq_abort` are 0, and `strap_q` is 2'b00.
- R2: `sd_n_in` passes through a two-flop synchroniser. A level change that is driven before clock edge 1 first shows on the outputs after clock edge 3, and not after edge 2.
- R3: In mode 2'b00, a low pin runs these steps in order: `ramp_req` alone, then `switch_stop`, then `ana_pd` and `dig_pd` together with `switch_stop` still high, then `hw_off`. `switch_stop`, `ana_pd` and `dig_pd` stay high through both shutdown states.
- R4: When `ramp_en` is 0 at the moment shutdown starts, the ramp step is skipped, `ramp_req` never rises, and `switch_stop` is the first step.
- R5: A step ends on the edge after its done input (`ramp_done`, `halt_done`, `pdn_done`) is seen high. Otherwise it ends after `tmo_cycles` cycles in the step, with a minimum of 1.
- R6: In mode 2'b01, the block enters hardware shutdown (`hw_off`=1) straight from the running state and skips every step.
- R7: On each entry to hardware shutdown, `reg_reset` is high for exactly one cycle and `strap_q` is cleared to 2'b00. `bus_en` is 0 from the start of a hardware-mode shutdown until release.
- R8: In mode 2'b10, the same steps run and end in software shutdown (`sw_off`=1). `bus_en` stays 1, `reg_reset` stays 0 and `strap_q` keeps its value.
- R9: On release of the pin in either shutdown state, `strap_q` takes {`strap_b`,`strap_a`}, `sw_off` becomes 1, `hw_off` becomes 0 and `bus_en` becomes 1.
- R10: A release during any step sets `seq_abort`, which stays set until reset. The steps and the mode's final shutdown state still complete before the release is honoured.
- R11: Mode 2'b11 behaves exactly like mode 2'b00.
- R12: From the released software-shutdown state, a new low pin goes straight to hardware shutdown in modes 00, 01 and 11, or to software shutdown with straps kept in mode 10, without running any steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_n_in | input | 1 | Asynchronous active-low shutdown pin |
| mode_sel | input | 2 | Shutdown mode field |
| ramp_en | input | 1 | Enables the volume ramp step |
| tmo_cycles | input | TMR_W | Per-step timeout in cycles |
| ramp_done | input | 1 | Volume ramp finished |
| halt_done | input | 1 | Switching stage stopped |
| pdn_done | input | 1 | Analog/digital power-down finished |
| strap_a | input | 1 | Address strap, low bit |
| strap_b | input | 1 | Address strap, high bit |
| ramp_req | output | 1 | Volume ramp-down request |
| switch_stop | output | 1 | Stop switching stage |
| ana_pd | output | 1 | Analog power-down enable |
| dig_pd | output | 1 | Digital power-down enable |
| reg_reset | output | 1 | One-cycle register-default strobe |
| bus_en | output | 1 | Control-bus enable |
| hw_off | output | 1 | In hardware shutdown |
| sw_off | output | 1 | In software shutdown |
| seq_abort | output | 1 | Sticky early-release error |
| strap_q | output | 2 | Latched straps {strap_b, strap_a} |

## Verification
The hardest case to reach from the ports is an early release in the middle of a step. The pin must rise after the step has begun but before its timeout, and the release has to cross the synchroniser before it can be seen. The stimulus sets a timeout long enough that the ramp step is still running two cycles after the release. It then follows the remaining timeouts cycle by cycle and checks that `hw_off` and `reg_reset` still appear before the move to software shutdown.

// File: rtl/sdn_pkg.sv
package sdn_pkg;

    typedef enum logic [1:0] {
        MODE_HW_SEQ  = 2'b00,
        MODE_HW_NOW  = 2'b01,
        MODE_SW_KEEP = 2'b10,
        MODE_RSVD    = 2'b11
    } sd_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_RAMP,
        ST_HALT,
        ST_PDN,
        ST_HW_OFF,
        ST_SW_HOLD,
        ST_SW_IDLE
    } sd_state_e;

    typedef struct packed {
        logic ramp_req;
        logic sw_stop;
        logic ana_pd;
        logic dig_pd;
        logic bus_en;
        logic hw_off;
        logic sw_off;
    } sd_ctrl_t;

    // Reserved encoding falls back to the sequenced hardware shutdown.
    function automatic sd_mode_e norm_mode(logic [1:0] m);
        return (m == 2'b11) ? MODE_HW_SEQ : sd_mode_e'(m);
    endfunction

    function automatic logic is_step(sd_state_e s);
        return (s == ST_RAMP) || (s == ST_HALT) || (s == ST_PDN);
    endfunction

    function automatic sd_ctrl_t decode_ctrl(sd_state_e s, sd_mode_e m);
        sd_ctrl_t c;
        logic     off;
        off        = (s == ST_HW_OFF) || (s == ST_SW_HOLD) || (s == ST_SW_IDLE);
        c.ramp_req = (s == ST_RAMP);
        c.sw_stop  = (s == ST_HALT) || (s == ST_PDN) || off;
        c.ana_pd   = (s == ST_PDN) || off;
        c.dig_pd   = (s == ST_PDN) || off;
        c.hw_off   = (s == ST_HW_OFF);
        c.sw_off   = (s == ST_SW_HOLD) || (s == ST_SW_IDLE);
        c.bus_en   = (s == ST_RUN) || c.sw_off ||
                     (is_step(s) && (m == MODE_SW_KEEP));
        return c;
    endfunction

endpackage

// File: rtl/sdn_sync.sv
module sdn_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sdn_step_timer.sv
module sdn_step_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam int XW = W + 1;

    logic [W-1:0] cnt;

    // Expires in the cycle where the step has lasted "limit" cycles (min 1).
    assign expired = ({1'b0, cnt} + XW'(1)) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (!expired)  cnt <= cnt + W'(1);
    end

    assert_timer_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (!restart && !expired) |=> (cnt != '0));

    assert_timer_clear_R5: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));
endmodule

// File: rtl/sdn_fsm.sv
module sdn_fsm
    import sdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sd_low,
    input  logic [1:0] mode_sel,
    input  logic       ramp_en,
    input  logic       ramp_done,
    input  logic       halt_done,
    input  logic       pdn_done,
    input  logic       tmo,
    input  logic [1:0] strap_in,
    output sd_ctrl_t   ctrl,
    output logic       reg_reset,
    output logic       seq_abort,
    output logic [1:0] strap_q,
    output logic       step_restart
);
    sd_state_e st, nxt;
    sd_mode_e  mode_q, mode_nxt, mode_live;

    assign mode_live = norm_mode(mode_sel);

    always_comb begin
        nxt      = st;
        mode_nxt = mode_q;
        unique case (st)
            ST_RUN: if (sd_low) begin
                mode_nxt = mode_live;
                if (mode_live == MODE_HW_NOW) nxt = ST_HW_OFF;
                else if (ramp_en)             nxt = ST_RAMP;
                else                          nxt = ST_HALT;
            end
            ST_RAMP:    if (ramp_done || tmo) nxt = ST_HALT;
            ST_HALT:    if (halt_done || tmo) nxt = ST_PDN;
            ST_PDN:     if (pdn_done || tmo)
                            nxt = (mode_q == MODE_SW_KEEP) ? ST_SW_HOLD : ST_HW_OFF;
            ST_HW_OFF:  if (!sd_low) nxt = ST_SW_IDLE;
            ST_SW_HOLD: if (!sd_low) nxt = ST_SW_IDLE;
            ST_SW_IDLE: if (sd_low) begin
                mode_nxt = mode_live;
                nxt = (mode_live == MODE_SW_KEEP) ? ST_SW_HOLD : ST_HW_OFF;
            end
            default:    nxt = ST_RUN;
        endcase
    end

    assign step_restart = (nxt != st);
    assign ctrl         = decode_ctrl(st, mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RUN;
            mode_q    <= MODE_HW_SEQ;
            reg_reset <= 1'b0;
            seq_abort <= 1'b0;
            strap_q   <= 2'b00;
        end else begin
            st        <= nxt;
            mode_q    <= mode_nxt;
            reg_reset <= (nxt == ST_HW_OFF) && (st != ST_HW_OFF);
            if (is_step(st) && !sd_low) seq_abort <= 1'b1;
            if ((nxt == ST_SW_IDLE) && (st != ST_SW_IDLE))
                strap_q <= strap_in;
            else if ((nxt == ST_HW_OFF) && (st != ST_HW_OFF))
                strap_q <= 2'b00;
        end
    end

    assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        reg_reset |=> !reg_reset);

    assert_hw_bus_off_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.hw_off |-> !ctrl.bus_en);

    assert_ramp_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.ramp_req) |-> $past(ramp_en));

    assert_step_order_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl.ana_pd |-> ctrl.sw_stop);

    assert_abort_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        seq_abort |=> seq_abort);

    assert_keep_no_reset_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.sw_off |-> !reg_reset);

    assert_release_latch_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_SW_IDLE) |-> (strap_q == $past(strap_in)));

    assert_now_skip_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_RUN && st != ST_RUN && mode_q == MODE_HW_NOW) |-> ctrl.hw_off);
endmodule

// File: rtl/shutdown_seq_top.sv
module shutdown_seq_top
    import sdn_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sd_n_in,
    input  logic [1:0]       mode_sel,
    input  logic             ramp_en,
    input  logic [TMR_W-1:0] tmo_cycles,
    input  logic             ramp_done,
    input  logic             halt_done,
    input  logic             pdn_done,
    input  logic             strap_a,
    input  logic             strap_b,
    output logic             ramp_req,
    output logic             switch_stop,
    output logic             ana_pd,
    output logic             dig_pd,
    output logic             reg_reset,
    output logic             bus_en,
    output logic             hw_off,
    output logic             sw_off,
    output logic             seq_abort,
    output logic [1:0]       strap_q
);
    logic     sd_sync;
    logic     tmo;
    logic     restart;
    sd_ctrl_t ctrl;

    sdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sd_n_in),
        .dout(sd_sync)
    );

    sdn_step_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .limit  (tmo_cycles),
        .expired(tmo)
    );

    sdn_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sd_low      (!sd_sync),
        .mode_sel    (mode_sel),
        .ramp_en     (ramp_en),
        .ramp_done   (ramp_done),
        .halt_done   (halt_done),
        .pdn_done    (pdn_done),
        .tmo         (tmo),
        .strap_in    ({strap_b, strap_a}),
        .ctrl        (ctrl),
        .reg_reset   (reg_reset),
        .seq_abort   (seq_abort),
        .strap_q     (strap_q),
        .step_restart(restart)
    );

    assign ramp_req    = ctrl.ramp_req;
    assign switch_stop = ctrl.sw_stop;
    assign ana_pd      = ctrl.ana_pd;
    assign dig_pd      = ctrl.dig_pd;
    assign bus_en      = ctrl.bus_en;
    assign hw_off      = ctrl.hw_off;
    assign sw_off      = ctrl.sw_off;

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(hw_off && sw_off));
endmodule

// File: tb/tb_shutdown_seq_top.sv
module tb_shutdown_seq_top;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sd_n_in = 1'b1;
    logic [1:0]    mode_sel = 2'b00;
    logic          ramp_en = 1'b0;
    logic [TW-1:0] tmo_cycles = 16'd8;
    logic          ramp_done = 1'b0, halt_done = 1'b0, pdn_done = 1'b0;
    logic          strap_a = 1'b0, strap_b = 1'b0;
    logic          ramp_req, switch_stop, ana_pd, dig_pd, reg_reset, bus_en;
    logic          hw_off, sw_off, seq_abort;
    logic [1:0]    strap_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    shutdown_seq_top #(.TMR_W(TW)) dut (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sd_n_in = 1'b1;
        ramp_done = 1'b0; halt_done = 1'b0; pdn_done = 1'b0;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bus_en", {1'b0, bus_en}, 2'b01);
        chk("R1 outputs", {1'b0, ramp_req | switch_stop | ana_pd | dig_pd | reg_reset}, 2'b00);
        chk("R1 flags", {1'b0, hw_off | sw_off | seq_abort}, 2'b00);
        chk("R1 strap_q", strap_q, 2'b00);
    endtask

    task automatic t_mode00_ramp();
        do_reset();
        mode_sel = 2'b00; ramp_en = 1'b1; tmo_cycles = 16'd8;
        strap_a = 1'b1; strap_b = 1'b0;
        sd_n_in = 1'b0;
        tick(2);
        chk("R2 no reaction yet", {1'b0, ramp_req}, 2'b00);
        tick(1);
        chk("R2 R3 ramp step", {ramp_req, switch_stop}, 2'b10);
        chk("R7 bus off in sequence", {1'b0, bus_en}, 2'b00);
        ramp_done = 1'b1; tick(1); ramp_done = 1'b0;
        chk("R3 R5 halt after done", {ramp_req, switch_stop}, 2'b01);
        chk("R3 no pd yet", {ana_pd, dig_pd}, 2'b00);
        tick(7);
        chk("R5 halt before timeout", {1'b0, ana_pd}, 2'b00);
        tick(1);
        chk("R5 pd after timeout", {ana_pd, dig_pd}, 2'b11);
        chk("R3 stop held", {1'b0, switch_stop}, 2'b01);
        pdn_done = 1'b1; tick(1); pdn_done = 1'b0;
        chk("R3 hw_off", {hw_off, sw_off}, 2'b10);
        chk("R7 reg_reset pulse", {reg_reset, bus_en}, 2'b10);
        chk("R3 outputs held", {switch_stop, ana_pd}, 2'b11);
        tick(1);
        chk("R7 pulse one cycle", {1'b0, reg_reset}, 2'b00);
        sd_n_in = 1'b1;
        tick(2);
        chk("R2 release not yet", {1'b0, hw_off}, 2'b01);
        tick(1);
        chk("R9 sw_off on release", {hw_off, sw_off}, 2'b01);
        chk("R9 straps latched", strap_q, 2'b01);
        chk("R9 bus on", {1'b0, bus_en}, 2'b01);
    endtask

    task automatic t_mode01();
        do_reset();
        mode_sel = 2'b01; ramp_en = 1'b1; tmo_cycles = 16'd8;
        sd_n_in = 1'b0;
        tick(3);
        chk("R6 immediate hw_off", {hw_off, ramp_req}, 2'b10);
        chk("R6 R7 reset strobe, bus off", {reg_reset, bus_en}, 2'b10);
        tick(1);
        chk("R7 strobe ends", {reg_reset, hw_off}, 2'b01);
    endtask

    task automatic t_noramp();
        do_reset();
        mode_sel = 2'b00; ramp_en = 1'b0; tmo_cycles = 16'd3;
        sd_n_in = 1'b0;
        tick(3);
        chk("R4 ramp skipped", {ramp_req, switch_stop}, 2'b01);
        tick(2);
        chk("R4 R5 halt held", {1'b0, ana_pd}, 2'b00);
        tick(1);
        chk("R5 pd after 3", {ana_pd, dig_pd}, 2'b11);
        tick(3);
        chk("R5 hw_off after 3", {hw_off, reg_reset}, 2'b11);
    endtask

    task automatic t_mode10();
        do_reset();
        mode_sel = 2'b10; ramp_en = 1'b1; tmo_cycles = 16'd40;
        sd_n_in = 1'b0;
        tick(3);
        chk("R8 ramp with bus on", {ramp_req, bus_en}, 2'b11);
        ramp_done = 1'b1; tick(1); ramp_done = 1'b0;
        chk("R8 halt bus on", {switch_stop, bus_en}, 2'b11);
        halt_done = 1'b1; tick(1); halt_done = 1'b0;
        chk("R8 pd", {ana_pd, dig_pd}, 2'b11);
        pdn_done = 1'b1; tick(1); pdn_done = 1'b0;
        chk("R8 sw shutdown", {hw_off, sw_off}, 2'b01);
        chk("R8 no strobe, bus on", {reg_reset, bus_en}, 2'b01);
        strap_a = 1'b0; strap_b = 1'b1;
        sd_n_in = 1'b1;
        tick(3);
        chk("R9 straps from sw", strap_q, 2'b10);
        sd_n_in = 1'b0;
        tick(3);
        chk("R12 mode10 re-entry", {hw_off, sw_off}, 2'b01);
        chk("R12 R8 straps kept", strap_q, 2'b10);
        chk("R12 no steps", {1'b0, ramp_req}, 2'b00);
        strap_a = 1'b1; strap_b = 1'b1;
        sd_n_in = 1'b1;
        tick(3);
        chk("R9 straps again", strap_q, 2'b11);
        mode_sel = 2'b00;
        sd_n_in = 1'b0;
        tick(3);
        chk("R12 direct hw_off", {hw_off, reg_reset}, 2'b11);
        chk("R12 R7 straps cleared", strap_q, 2'b00);
        chk("R12 bus off", {1'b0, bus_en}, 2'b00);
    endtask

    task automatic t_abort();
        do_reset();
        mode_sel = 2'b00; ramp_en = 1'b1; tmo_cycles = 16'd5;
        sd_n_in = 1'b0;
        tick(3);
        chk("R10 in ramp", {1'b0, ramp_req}, 2'b01);
        sd_n_in = 1'b1;
        tick(2);
        chk("R10 abort not yet", {1'b0, seq_abort}, 2'b00);
        tick(1);
        chk("R10 abort flagged", {seq_abort, ramp_req}, 2'b11);
        tick(2);
        chk("R10 halt continues", {switch_stop, sw_off}, 2'b10);
        tick(5);
        chk("R10 pd continues", {ana_pd, sw_off}, 2'b10);
        tick(5);
        chk("R10 hw_off before release", {hw_off, reg_reset}, 2'b11);
        tick(1);
        chk("R10 then sw_off", {hw_off, sw_off}, 2'b01);
        chk("R10 abort sticky", {1'b0, seq_abort}, 2'b01);
    endtask

    task automatic t_mode11();
        do_reset();
        mode_sel = 2'b11; ramp_en = 1'b1; tmo_cycles = 16'd2;
        sd_n_in = 1'b0;
        tick(3);
        chk("R11 ramp like 00", {ramp_req, bus_en}, 2'b10);
        tick(5);
        chk("R11 pd", {ana_pd, hw_off}, 2'b10);
        tick(1);
        chk("R11 hw_off", {hw_off, reg_reset}, 2'b11);
    endtask

    initial begin
        t_reset();
        t_mode00_ramp();
        t_mode01();
        t_noramp();
        t_mode10();
        t_abort();
        t_mode11();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule